// File: doc/BRIEF.md
# Non-volatile Memory Controller with Power-up Write Lockout

This block stands between a processor's register-level write strobes and a page-organised store of program flash and data EEPROM. Software fills a one-page staging buffer byte by byte and then starts a page operation: erase-then-program, erase alone, a staging-buffer clear or a no-operation. Every command must be armed by a key byte written shortly before it. Flash operations raise a flash-busy flag and stall the processor until they finish. EEPROM operations raise only the EEPROM-busy flag. The program time is a parameter counted in clock cycles.

After a power-on reset the controller keeps a write lockout window open for a parameterised number of cycles, 6667 by default. That is about 2 ms at a 3.33 MHz clock. While the window is open, both busy flags read 1 and every staging-buffer write and command is dropped without a trace, so the error flag stays put. Two configuration levels are sampled during reset, an enable bit and a reset-pin-as-debug-port select, and either of them can suppress the window. A reset that is not a power-on reset leaves the window timer alone.

Top module: `nvm_lockout_ctrl`

## Requirements
- R1: After a reset with `por`=1, `cfg_tout_en`=1 and `cfg_rstpin_dbg`=0, `fbusy` and `eebusy` both read 1 for exactly LOCK_CYC clock cycles after `rst` falls and read 0 from then on. During this time `wr_err` reads 0 and `cpu_stall` reads 0.
- R2: While the window is open, staging-buffer writes and commands, unlocked or not, change neither the array nor the staging buffer.
- R3: A write or command dropped during the window never changes `wr_err`, even when the command code is invalid.
- R4: If `cfg_tout_en`=0 or `cfg_rstpin_dbg`=1 while `rst` is high, no window follows, and both busy flags read 0 in the first cycle after reset.
- R5: A reset with `por`=0 does not restart an expired window. Both busy flags read 0 right after it.
- R6: A command counts only if a `key_wr` carrying 8'hA5 was seen 1 to 4 cycles before `cmd_wr`. A later command, a command after a wrong key byte, or a command with no key is ignored: no operation starts and `wr_err` keeps its value.
- R7: Command code 1 (erase-write) on a flash page fills that page from the staging buffer. Bytes that were never written read 8'hFF. `fbusy` and `cpu_stall` stay high for exactly PROG_CYC cycles from the accepting edge.
- R8: Command code 2 (erase) sets every byte of the target page to 8'hFF.
- R9: The staging buffer returns to all 8'hFF after each completed erase-write and on command code 3 (buffer clear).
- R10: `cmd_tgt`=1 selects the EEPROM. An EEPROM operation raises `eebusy` for PROG_CYC cycles while `fbusy` and `cpu_stall` stay 0.
- R11: Codes 4 to 7, a flash page below APP_FIRST, or an EEPROM page at or above EE_PAGES sets `wr_err` and starts nothing. The next valid command (code 0 included) clears it.
- R12: While either busy flag is 1, staging-buffer writes and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por | input | 1 | Qualifies the reset as power-on |
| cfg_tout_en | input | 1 | Lockout enable, sampled in reset (0 disables) |
| cfg_rstpin_dbg | input | 1 | Reset pin used as debug port, sampled in reset (1 disables) |
| key_wr | input | 1 | Key register write strobe |
| key_data | input | 8 | Key byte |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | 3 | 0 nop, 1 erase-write, 2 erase, 3 buffer clear |
| cmd_tgt | input | 1 | 0 flash, 1 EEPROM |
| cmd_page | input | PW | Target page |
| buf_wr | input | 1 | Staging-buffer write strobe |
| buf_idx | input | BW | Byte index within the page |
| buf_data | input | 8 | Byte to stage |
| rd_tgt | input | 1 | Read select, 0 flash, 1 EEPROM |
| rd_page | input | PW | Read page |
| rd_idx | input | BW | Read byte index |
| rd_data | output | 8 | Read byte, one cycle after the address |
| fbusy | output | 1 | Flash busy or lockout |
| eebusy | output | 1 | EEPROM busy or lockout |
| wr_err | output | 1 | Invalid command or page |
| cpu_stall | output | 1 | Processor held during flash operation |

## Verification
An accepted command shows `fbusy` or `eebusy` and `wr_err` at the first sample after its accepting edge. The busy flag then stays high for PROG_CYC samples, and the array holds the new data at the sample where busy has dropped. Read data appears one cycle after the read address is applied. The lockout edge is checked against a cycle counter that starts when reset falls: the bench samples once after LOCK_CYC-1 edges and once after LOCK_CYC edges. All inputs change and all outputs are sampled on the falling clock edge, so each check lands in the cycle it is meant for.

// File: rtl/nvmc_pkg.sv
package nvmc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_ERWR   = 3'd1,
        CMD_ERASE  = 3'd2,
        CMD_BUFCLR = 3'd3
    } nvm_cmd_e;

    typedef enum logic {
        TGT_FLASH = 1'b0,
        TGT_EE    = 1'b1
    } nvm_tgt_e;

    typedef struct packed {
        logic     busy;
        nvm_tgt_e tgt;
        logic     erase_only;
    } nvm_op_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic logic code_known(input logic [2:0] c);
        return c <= 3'd3;
    endfunction

    function automatic logic touches_page(input logic [2:0] c);
        return (c == CMD_ERWR) || (c == CMD_ERASE);
    endfunction

endpackage

// File: rtl/nvm_por_lockout.sv
module nvm_por_lockout #(
    parameter int LOCK_CYC    = 6667,
    parameter bit PIN_RESTART = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic cfg_tout_en,
    input  logic cfg_rstpin_dbg,
    output logic lock
);
    localparam int LCW = $clog2(LOCK_CYC + 1);

    logic [LCW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            if (por || PIN_RESTART)
                cnt <= (cfg_tout_en && !cfg_rstpin_dbg) ? LCW'(LOCK_CYC) : '0;
        end else if (cnt != '0) begin
            cnt <= cnt - LCW'(1);
        end
    end

    assign lock = (cnt != '0);

    // R1
    window_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt == $past(cnt) - LCW'(1)));

endmodule

// File: rtl/nvm_unlock_gate.sv
module nvm_unlock_gate #(
    parameter logic [7:0] KEY        = 8'hA5,
    parameter int         UNLOCK_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       cmd_wr,
    output logic       unlocked
);
    localparam int UW = $clog2(UNLOCK_CYC + 1);

    logic [UW-1:0] win;

    always_ff @(posedge clk) begin
        if (rst)
            win <= '0;
        else if (key_wr)
            win <= (key_data == KEY) ? UW'(UNLOCK_CYC) : '0;
        else if (cmd_wr)
            win <= '0;
        else if (win != '0)
            win <= win - UW'(1);
    end

    assign unlocked = (win != '0);

    // R6
    unlock_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        (win != '0 && !key_wr) |=> (win < $past(win)));

endmodule

// File: rtl/nvm_page_array.sv
module nvm_page_array
    import nvmc_pkg::*;
#(
    parameter int FLASH_PAGES = 8,
    parameter int EE_PAGES    = 2,
    parameter int PAGE_BYTES  = 128
) (
    input  logic                               clk,
    input  logic                               commit,
    input  nvm_tgt_e                           tgt,
    input  logic [$clog2(FLASH_PAGES)-1:0]     page,
    input  logic                               erase_only,
    input  logic [PAGE_BYTES-1:0][7:0]         wpage,
    input  logic                               rd_tgt,
    input  logic [$clog2(FLASH_PAGES)-1:0]     rd_page,
    input  logic [$clog2(PAGE_BYTES)-1:0]      rd_idx,
    output logic [7:0]                         rd_data
);
    localparam int PW  = $clog2(FLASH_PAGES);
    localparam int BW  = $clog2(PAGE_BYTES);
    localparam int EPW = $clog2(EE_PAGES);

    logic [7:0] fmem [FLASH_PAGES*PAGE_BYTES];
    logic [7:0] emem [EE_PAGES*PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (tgt == TGT_EE)
                    emem[{page[EPW-1:0], BW'(i)}] <= erase_only ? ERASED_BYTE : wpage[i];
                else
                    fmem[{page, BW'(i)}] <= erase_only ? ERASED_BYTE : wpage[i];
            end
        end
        if (rd_tgt)
            rd_data <= (int'(rd_page) < EE_PAGES) ? emem[{rd_page[EPW-1:0], rd_idx}] : ERASED_BYTE;
        else
            rd_data <= fmem[{rd_page, rd_idx}];
    end

endmodule

// File: rtl/nvm_lockout_ctrl.sv
module nvm_lockout_ctrl
    import nvmc_pkg::*;
#(
    parameter int         FLASH_PAGES = 8,
    parameter int         APP_FIRST   = 2,
    parameter int         EE_PAGES    = 2,
    parameter int         PAGE_BYTES  = 128,
    parameter int         LOCK_CYC    = 6667,
    parameter int         PROG_CYC    = 20,
    parameter int         UNLOCK_CYC  = 4,
    parameter logic [7:0] KEY         = 8'hA5,
    parameter bit         PIN_RESTART = 1'b0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           por,
    input  logic                           cfg_tout_en,
    input  logic                           cfg_rstpin_dbg,
    input  logic                           key_wr,
    input  logic [7:0]                     key_data,
    input  logic                           cmd_wr,
    input  logic [2:0]                     cmd_code,
    input  logic                           cmd_tgt,
    input  logic [$clog2(FLASH_PAGES)-1:0] cmd_page,
    input  logic                           buf_wr,
    input  logic [$clog2(PAGE_BYTES)-1:0]  buf_idx,
    input  logic [7:0]                     buf_data,
    input  logic                           rd_tgt,
    input  logic [$clog2(FLASH_PAGES)-1:0] rd_page,
    input  logic [$clog2(PAGE_BYTES)-1:0]  rd_idx,
    output logic [7:0]                     rd_data,
    output logic                           fbusy,
    output logic                           eebusy,
    output logic                           wr_err,
    output logic                           cpu_stall
);
    localparam int PW = $clog2(FLASH_PAGES);
    localparam int CW = $clog2(PROG_CYC + 1);

    logic                       lock;
    logic                       unlocked;
    nvm_op_t                    op;
    logic [PW-1:0]              op_page;
    logic [CW-1:0]              op_cnt;
    logic [PAGE_BYTES-1:0][7:0] pbuf;
    logic                       err_q;
    logic                       busy_any;
    logic                       cmd_take;
    logic                       page_ok;
    logic                       cmd_bad;
    logic                       commit;

    nvm_por_lockout #(.LOCK_CYC(LOCK_CYC), .PIN_RESTART(PIN_RESTART)) u_window (
        .clk(clk), .rst(rst), .por(por), .cfg_tout_en(cfg_tout_en),
        .cfg_rstpin_dbg(cfg_rstpin_dbg), .lock(lock)
    );

    nvm_unlock_gate #(.KEY(KEY), .UNLOCK_CYC(UNLOCK_CYC)) u_key (
        .clk(clk), .rst(rst), .key_wr(key_wr), .key_data(key_data),
        .cmd_wr(cmd_wr), .unlocked(unlocked)
    );

    always_comb begin
        fbusy     = lock | (op.busy & (op.tgt == TGT_FLASH));
        eebusy    = lock | (op.busy & (op.tgt == TGT_EE));
        cpu_stall = op.busy & (op.tgt == TGT_FLASH);
        busy_any  = fbusy | eebusy;
        cmd_take  = cmd_wr & unlocked & ~busy_any;
        if (cmd_tgt)
            page_ok = int'(cmd_page) < EE_PAGES;
        else
            page_ok = (int'(cmd_page) >= APP_FIRST) && (int'(cmd_page) < FLASH_PAGES);
        cmd_bad   = !code_known(cmd_code) || (touches_page(cmd_code) && !page_ok);
        commit    = op.busy && (op_cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op      <= '{busy: 1'b0, tgt: TGT_FLASH, erase_only: 1'b0};
            op_page <= '0;
            op_cnt  <= '0;
            err_q   <= 1'b0;
            pbuf    <= {PAGE_BYTES{ERASED_BYTE}};
        end else begin
            if (op.busy) begin
                if (op_cnt == '0) begin
                    op.busy <= 1'b0;
                    if (!op.erase_only)
                        pbuf <= {PAGE_BYTES{ERASED_BYTE}};
                end else begin
                    op_cnt <= op_cnt - CW'(1);
                end
            end else if (cmd_take) begin
                err_q <= cmd_bad;
                if (!cmd_bad) begin
                    if (touches_page(cmd_code)) begin
                        op.busy       <= 1'b1;
                        op.tgt        <= nvm_tgt_e'(cmd_tgt);
                        op.erase_only <= (cmd_code == CMD_ERASE);
                        op_page       <= cmd_page;
                        op_cnt        <= CW'(PROG_CYC - 1);
                    end else if (cmd_code == CMD_BUFCLR) begin
                        pbuf <= {PAGE_BYTES{ERASED_BYTE}};
                    end
                end
            end
            if (buf_wr && !busy_any)
                pbuf[buf_idx] <= buf_data;
        end
    end

    assign wr_err = err_q;

    nvm_page_array #(
        .FLASH_PAGES(FLASH_PAGES), .EE_PAGES(EE_PAGES), .PAGE_BYTES(PAGE_BYTES)
    ) u_array (
        .clk(clk), .commit(commit), .tgt(op.tgt), .page(op_page),
        .erase_only(op.erase_only), .wpage(pbuf), .rd_tgt(rd_tgt),
        .rd_page(rd_page), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // R3
    lockout_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && (cmd_wr || buf_wr)) |=> $stable(err_q));

    // R6
    start_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(op.busy) |-> $past(unlocked && !lock));

    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (op.busy && op_cnt != '0) |=> op.busy);

    // R12
    buf_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (op.busy && op_cnt != '0 && buf_wr) |=> $stable(pbuf));

    // R10
    single_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !lock |-> !(fbusy && eebusy));

endmodule

// File: tb/tb_nvm_lockout_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_lockout_ctrl;
    localparam int L    = 6667;
    localparam int P    = 20;
    localparam int WDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b0, por = 1'b0, cfg_tout_en = 1'b1, cfg_rstpin_dbg = 1'b0;
    logic key_wr = 1'b0, cmd_wr = 1'b0, cmd_tgt = 1'b0, buf_wr = 1'b0, rd_tgt = 1'b0;
    logic [7:0] key_data = '0, buf_data = '0, rd_data;
    logic [2:0] cmd_code = '0, cmd_page = '0, rd_page = '0;
    logic [6:0] buf_idx = '0, rd_idx = '0;
    logic fbusy, eebusy, wr_err, cpu_stall;

    int cyc = 0, rel = 0, n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nvm_lockout_ctrl #(.LOCK_CYC(L), .PROG_CYC(P)) dut (
        .clk(clk), .rst(rst), .por(por), .cfg_tout_en(cfg_tout_en),
        .cfg_rstpin_dbg(cfg_rstpin_dbg), .key_wr(key_wr), .key_data(key_data),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .cmd_tgt(cmd_tgt), .cmd_page(cmd_page),
        .buf_wr(buf_wr), .buf_idx(buf_idx), .buf_data(buf_data), .rd_tgt(rd_tgt),
        .rd_page(rd_page), .rd_idx(rd_idx), .rd_data(rd_data), .fbusy(fbusy),
        .eebusy(eebusy), .wr_err(wr_err), .cpu_stall(cpu_stall)
    );

    // {tgt, page[2:0], code[2:0], exp_err, exp_fbusy, exp_eebusy}
    localparam logic [9:0] VEC [9] = '{
        10'b0_010_001_0_1_0,   // R7 flash erase-write page 2
        10'b0_001_001_1_0_0,   // R11 page below application area
        10'b0_000_000_0_0_0,   // R11 nop clears error
        10'b0_011_101_1_0_0,   // R11 code 5
        10'b1_001_010_0_0_1,   // R10 eeprom erase page 1
        10'b1_010_001_1_0_0,   // R11 eeprom page 2 out of range
        10'b0_111_010_0_1_0,   // R8 flash erase page 7
        10'b0_000_111_1_0_0,   // R11 code 7
        10'b0_000_011_0_0_0    // R11 buffer clear is valid
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic p, input logic en, input logic dbg);
        rst = 1'b1; por = p; cfg_tout_en = en; cfg_rstpin_dbg = dbg;
        repeat (2) @(negedge clk);
        rst = 1'b0; por = 1'b0; cfg_tout_en = 1'b1; cfg_rstpin_dbg = 1'b0;
        rel = cyc;
    endtask

    task automatic wr_buf(input int idx, input logic [7:0] d);
        buf_wr = 1'b1; buf_idx = 7'(idx); buf_data = d;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic issue(input logic t, input int pg, input logic [2:0] code,
                         input int gap, input logic [7:0] key);
        key_wr = 1'b1; key_data = key;
        @(negedge clk);
        key_wr = 1'b0;
        repeat (gap - 1) @(negedge clk);
        cmd_wr = 1'b1; cmd_tgt = t; cmd_page = 3'(pg); cmd_code = code;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200 && (fbusy || eebusy); k++) @(negedge clk);
    endtask

    task automatic rd(input logic t, input int pg, input int idx, output logic [7:0] d);
        rd_tgt = t; rd_page = 3'(pg); rd_idx = 7'(idx);
        @(negedge clk);
        d = rd_data;
    endtask

    initial begin
        wait (cyc >= WDOG);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, WDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        @(negedge clk);

        // power-on reset, lockout window
        do_reset(1'b1, 1'b1, 1'b0);
        chk("R1 fbusy after por", fbusy, 1);
        chk("R1 eebusy after por", eebusy, 1);
        chk("R1 wr_err after por", wr_err, 0);
        chk("R1 cpu_stall after por", cpu_stall, 0);
        wr_buf(7, 8'h3C);
        issue(1'b0, 4, 3'd6, 1, 8'hA5);
        chk("R3 invalid code in window leaves wr_err", wr_err, 0);
        issue(1'b0, 4, 3'd1, 1, 8'hA5);
        chk("R3 erase-write in window leaves wr_err", wr_err, 0);
        while (cyc < rel + L - 1) @(negedge clk);
        chk("R1 fbusy last window cycle", fbusy, 1);
        chk("R1 eebusy last window cycle", eebusy, 1);
        @(negedge clk);
        chk("R1 fbusy after window", fbusy, 0);
        chk("R1 eebusy after window", eebusy, 0);

        // R2: staged byte from the window was dropped; R7 busy length
        issue(1'b0, 4, 3'd1, 1, 8'hA5);
        n = 0;
        while (fbusy && n < 200) begin
            if (!cpu_stall) chk("R7 cpu_stall during flash op", cpu_stall, 1);
            n++; @(negedge clk);
        end
        chk("R7 flash busy cycles", n, P);
        rd(1'b0, 4, 7, d);
        chk("R2 window buffer write discarded", d, 8'hFF);

        // R7 programming pattern
        for (int i = 0; i < 4; i++) wr_buf(i, 8'(8'h10 + i));
        wr_buf(127, 8'h77);
        issue(1'b0, 3, 3'd1, 1, 8'hA5);
        wait_idle();
        for (int i = 0; i < 4; i++) begin
            rd(1'b0, 3, i, d);
            chk("R7 programmed byte", d, 8'h10 + i);
        end
        rd(1'b0, 3, 127, d);
        chk("R7 last byte", d, 8'h77);
        rd(1'b0, 3, 50, d);
        chk("R7 unwritten byte erased", d, 8'hFF);

        // R9 buffer cleared after erase-write, and by clear command
        issue(1'b0, 5, 3'd1, 1, 8'hA5);
        wait_idle();
        rd(1'b0, 5, 0, d);
        chk("R9 buffer cleared after erase-write", d, 8'hFF);
        wr_buf(9, 8'h42);
        issue(1'b0, 0, 3'd3, 1, 8'hA5);
        issue(1'b0, 6, 3'd1, 1, 8'hA5);
        wait_idle();
        rd(1'b0, 6, 9, d);
        chk("R9 buffer clear command", d, 8'hFF);

        // R6 unlock window edges
        issue(1'b0, 6, 3'd2, 4, 8'hA5);
        chk("R6 command 4 cycles after key accepted", fbusy, 1);
        wait_idle();
        issue(1'b0, 3, 3'd2, 5, 8'hA5);
        chk("R6 command 5 cycles after key ignored", fbusy, 0);
        issue(1'b0, 3, 3'd2, 1, 8'h5A);
        chk("R6 wrong key ignored", fbusy, 0);
        issue(1'b0, 0, 3'd7, 1, 8'h00);
        chk("R6 ignored command keeps wr_err", wr_err, 0);
        rd(1'b0, 3, 0, d);
        chk("R6 page untouched by ignored erase", d, 8'h10);

        // R10 eeprom erase-write, R12 writes during op ignored
        wr_buf(3, 8'hE1);
        issue(1'b1, 0, 3'd1, 1, 8'hA5);
        chk("R10 eebusy", eebusy, 1);
        chk("R10 fbusy low", fbusy, 0);
        chk("R10 cpu_stall low", cpu_stall, 0);
        wr_buf(2, 8'h99);
        issue(1'b0, 3, 3'd2, 1, 8'hA5);
        wait_idle();
        rd(1'b1, 0, 3, d);
        chk("R10 eeprom data", d, 8'hE1);
        rd(1'b0, 3, 1, d);
        chk("R12 command during op ignored", d, 8'h11);
        issue(1'b0, 2, 3'd1, 1, 8'hA5);
        wait_idle();
        rd(1'b0, 2, 2, d);
        chk("R12 buffer write during op ignored", d, 8'hFF);

        // table walk
        for (int v = 0; v < 9; v++) begin
            issue(VEC[v][9], int'(VEC[v][8:6]), VEC[v][5:3], 1, 8'hA5);
            chk("R11 wr_err vector", wr_err, int'(VEC[v][2]));
            chk("R10 fbusy vector", fbusy, int'(VEC[v][1]));
            chk("R10 eebusy vector", eebusy, int'(VEC[v][0]));
            chk("R7 cpu_stall vector", cpu_stall, int'(VEC[v][1]));
            wait_idle();
        end
        rd(1'b0, 7, 0, d);
        chk("R8 erased page byte 0", d, 8'hFF);
        rd(1'b0, 7, 127, d);
        chk("R8 erased page byte 127", d, 8'hFF);
        rd(1'b1, 1, 3, d);
        chk("R8 eeprom erased", d, 8'hFF);

        // R2 array untouched during a second window; R5 pin reset
        do_reset(1'b1, 1'b1, 1'b0);
        issue(1'b0, 3, 3'd2, 1, 8'hA5);
        while (cyc < rel + L) @(negedge clk);
        rd(1'b0, 3, 0, d);
        chk("R2 erase in window discarded", d, 8'h10);
        do_reset(1'b0, 1'b1, 1'b0);
        chk("R5 pin reset no window fbusy", fbusy, 0);
        chk("R5 pin reset no window eebusy", eebusy, 0);

        // R4 bypass paths
        do_reset(1'b1, 1'b0, 1'b0);
        chk("R4 enable bit 0 fbusy", fbusy, 0);
        chk("R4 enable bit 0 eebusy", eebusy, 0);
        do_reset(1'b1, 1'b1, 1'b1);
        chk("R4 debug pin fbusy", fbusy, 0);
        chk("R4 debug pin eebusy", eebusy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule